// File: doc/BRIEF.md
# Print Engine Video Serializer

This block feeds a non-impact print engine. It reads a rendered bitmap out of memory and sends it to the engine as a one-bit serial video stream. Software programs six control registers: left margin, top margin, words per line, lines per page, image base address and a control word. Writing the control word arms the block. The block then fetches the first image words into a small prefetch buffer and waits for the engine to signal the top of the page. When frame sync arrives, the block raises a band-begin interrupt. It then skips the top-margin lines and streams each further line, starting a programmed number of pixel clocks after line sync. When the last pixel of the last line has gone out, it raises a page-end interrupt so that software can reuse the image memory.

The pixel clock comes from one of two places. The engine can supply it directly, or the block can recover it from an 8x reference clock. In the recovered mode, the divider is realigned on every line sync. Frame sync, line sync and the video clock each pass through a two-flop synchronizer, and their rising edges are detected in the system clock domain. Image words come in through a simple word-read interface: the block holds its request until the memory acknowledges it, and there is never more than one read in flight.

Top module: `pvid_serializer`

## Requirements
- R1: After reset, video_out, video_stb, mem_req, irq_band_begin, irq_page_end and underrun are all low.
- R2: Register indices are 0 left margin, 1 top margin, 2 words per line, 3 lines per page, 4 base word address, 5 control (bit 0 = 1 selects clock recovery). Only a write to index 5 arms the block, and it arms only when the block is idle. Writes to indices 0 to 4 start no activity.
- R3: Once armed, the block issues exactly FIFO_DEPTH word reads, at base and base+1, before frame sync. A request stays high with a stable address until it is acknowledged. Over the page, the block reads words per line times lines words at consecutive addresses.
- R4: A frame-sync rising edge while armed gives exactly one one-cycle irq_band_begin pulse. A frame sync while idle is ignored.
- R5: The first top-margin line syncs after frame sync produce no pixels.
- R6: On a data line, the first pixel goes out on pixel clock number left margin + 1 after line sync.
- R7: Each data line carries words-per-line × 16 pixels, one per pixel clock. Each pixel is marked by a one-cycle video_stb. Words come from consecutive addresses and are sent most significant bit first.
- R8: With bit 0 of the control register clear, each rising edge of eng_vclk is one pixel clock, and video_out changes only one cycle after such a pixel clock.
- R9: With bit 0 of the control register set, every eighth rising edge of eng_vclk is a pixel clock. The divider is cleared on each line sync, so the first pixel comes 8 × (left margin + 1) edges after line sync, whatever the phase before it.
- R10: After the last pixel of the last line, irq_page_end pulses once and the block goes idle. Later line syncs and clocks produce no pixels.
- R11: If a pixel is due while the prefetch buffer is empty, video_out gives 0 and underrun is set. Underrun stays set until the block is next armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | 16 | Register write data |
| mem_req | output | 1 | Word read request, held until acknowledged |
| mem_addr | output | 16 | Word address of the request |
| mem_ack | input | 1 | Read acknowledge; mem_rdata is valid |
| mem_rdata | input | WORD_W | Read data |
| eng_fsync | input | 1 | Engine frame sync (asynchronous) |
| eng_lsync | input | 1 | Engine line sync (asynchronous) |
| eng_vclk | input | 1 | Engine video clock, or 8x reference (asynchronous) |
| video_out | output | 1 | Serial video |
| video_stb | output | 1 | One-cycle marker of a new pixel on video_out |
| irq_band_begin | output | 1 | Band-begin interrupt pulse |
| irq_page_end | output | 1 | Page-end interrupt pulse |
| underrun | output | 1 | Sticky prefetch underrun status |

## Verification
The bench builds the block with its default values: 16-bit words, a two-word prefetch buffer and a reference multiple of 8. With these values, a two-word read count before frame sync is exact, and the recovered clock gives its first pixel after 16 reference edges when the left margin is 1. Small pages of one to three lines, with widths of one to four words, make the page-end interrupt and the idle behaviour after it reachable within a few thousand cycles. A memory latency of 400 cycles against a fast video clock drains the two-word buffer, which triggers the underrun path and shows it being cleared by the next arming.

// File: rtl/pvid_pkg.sv
package pvid_pkg;

    localparam int REG_W     = 16;
    localparam int TOT_W     = 2 * REG_W;
    localparam int REG_CNT   = 6;
    localparam int REG_IDX_W = $clog2(REG_CNT);

    localparam logic [REG_IDX_W-1:0] IDX_LEFT  = REG_IDX_W'(0);
    localparam logic [REG_IDX_W-1:0] IDX_TOP   = REG_IDX_W'(1);
    localparam logic [REG_IDX_W-1:0] IDX_WPL   = REG_IDX_W'(2);
    localparam logic [REG_IDX_W-1:0] IDX_LINES = REG_IDX_W'(3);
    localparam logic [REG_IDX_W-1:0] IDX_BASE  = REG_IDX_W'(4);
    localparam logic [REG_IDX_W-1:0] IDX_CTRL  = REG_IDX_W'(5);

    typedef enum logic [2:0] {
        PV_IDLE,
        PV_ARMED,
        PV_TOP,
        PV_LWAIT,
        PV_LEFT,
        PV_DATA
    } pv_state_e;

    typedef struct packed {
        logic [REG_W-1:0] left;
        logic [REG_W-1:0] top;
        logic [REG_W-1:0] wpl;
        logic [REG_W-1:0] lines;
        logic [REG_W-1:0] base;
        logic             recover;
    } pv_cfg_t;

    function automatic logic [TOT_W-1:0] word_total(input logic [REG_W-1:0] wpl,
                                                    input logic [REG_W-1:0] lines);
        return TOT_W'(wpl) * TOT_W'(lines);
    endfunction

endpackage

// File: rtl/pvid_sync.sv
module pvid_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/pvid_regs.sv
module pvid_regs
    import pvid_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0]     wr_data,
    output pv_cfg_t              cfg,
    output logic                 arm
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            arm <= 1'b0;
        end else begin
            arm <= 1'b0;
            if (wr_en) begin
                case (wr_idx)
                    IDX_LEFT:  cfg.left  <= wr_data;
                    IDX_TOP:   cfg.top   <= wr_data;
                    IDX_WPL:   cfg.wpl   <= wr_data;
                    IDX_LINES: cfg.lines <= wr_data;
                    IDX_BASE:  cfg.base  <= wr_data;
                    IDX_CTRL: begin
                        cfg.recover <= wr_data[0];
                        arm         <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pvid_pixclk.sv
module pvid_pixclk #(
    parameter int REF_MULT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic recover,
    input  logic edge_in,
    input  logic line_start,
    output logic tick
);
    localparam int DIV_W = (REF_MULT > 1) ? $clog2(REF_MULT) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(REF_MULT - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || line_start) begin
            div_q <= '0;
        end else if (recover && edge_in) begin
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + DIV_W'(1);
        end
    end

    always_comb begin
        if (recover) tick = edge_in && !line_start && (div_q == DIV_LAST);
        else         tick = edge_in;
    end
endmodule

// File: rtl/pvid_fetch.sv
module pvid_fetch
    import pvid_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [REG_W-1:0]  base,
    input  logic [TOT_W-1:0]  total,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              empty,
    output logic              mem_req,
    output logic [REG_W-1:0]  mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WORD_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  fill;
    logic [TOT_W-1:0]  remain_q;
    logic [REG_W-1:0]  addr_q;
    logic              req_q;
    logic              push, do_pop;

    assign push     = req_q && mem_ack;
    assign do_pop   = pop && (fill != '0);
    assign empty    = (fill == '0);
    assign head     = slots[rd_ptr];
    assign mem_req  = req_q;
    assign mem_addr = addr_q;

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill     <= '0;
            remain_q <= '0;
            addr_q   <= '0;
            req_q    <= 1'b0;
        end else if (start) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill     <= '0;
            remain_q <= total;
            addr_q   <= base;
            req_q    <= 1'b0;
        end else begin
            if (push) begin
                wr_ptr   <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
                addr_q   <= addr_q + REG_W'(1);
                remain_q <= remain_q - TOT_W'(1);
                req_q    <= 1'b0;
            end else if (!req_q && remain_q != '0 && fill < CNT_W'(DEPTH)) begin
                req_q <= 1'b1;
            end
            if (do_pop) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
            case ({push, do_pop})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: ;
            endcase
        end
    end

    // R3
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> fill < CNT_W'(DEPTH));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q && !mem_ack && !start) |=> (req_q && $stable(addr_q)));
endmodule

// File: rtl/pvid_serializer.sv
module pvid_serializer
    import pvid_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int FIFO_DEPTH  = 2,
    parameter int REF_MULT    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [REG_IDX_W-1:0] cfg_idx,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic                 mem_req,
    output logic [REG_W-1:0]     mem_addr,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_rdata,
    input  logic                 eng_fsync,
    input  logic                 eng_lsync,
    input  logic                 eng_vclk,
    output logic                 video_out,
    output logic                 video_stb,
    output logic                 irq_band_begin,
    output logic                 irq_page_end,
    output logic                 underrun
);
    localparam int BIT_W      = $clog2(WORD_W);
    localparam int LINE_PIX_W = REG_W + $clog2(WORD_W);
    localparam int N_SYNC     = 3;

    pv_cfg_t   cfg;
    logic      arm, fetch_start;
    pv_state_e state;

    logic [N_SYNC-1:0] raw_in, rise_vec;
    logic fs_rise, ls_rise, vclk_rise, pix_tick;

    logic [WORD_W-1:0] head;
    logic              empty, pop;

    logic [REG_W-1:0]      top_cnt, line_cnt, left_cnt;
    logic [LINE_PIX_W-1:0] pix_cnt, line_pix;
    logic [BIT_W-1:0]      bit_left;
    logic [WORD_W-1:0]     sh_q;

    assign raw_in = {eng_vclk, eng_lsync, eng_fsync};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        pvid_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (raw_in[g]),
            .rise     (rise_vec[g])
        );
    end

    assign fs_rise   = rise_vec[0];
    assign ls_rise   = rise_vec[1];
    assign vclk_rise = rise_vec[2];

    pvid_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_wdata),
        .cfg     (cfg),
        .arm     (arm)
    );

    pvid_pixclk #(.REF_MULT(REF_MULT)) u_pixclk (
        .clk        (clk),
        .rst        (rst),
        .recover    (cfg.recover),
        .edge_in    (vclk_rise),
        .line_start (ls_rise),
        .tick       (pix_tick)
    );

    assign fetch_start = arm && (state == PV_IDLE);
    assign pop         = (state == PV_DATA) && pix_tick && (bit_left == '0);
    assign line_pix    = LINE_PIX_W'(cfg.wpl) * LINE_PIX_W'(WORD_W);

    pvid_fetch #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .start     (fetch_start),
        .base      (cfg.base),
        .total     (word_total(cfg.wpl, cfg.lines)),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= PV_IDLE;
            top_cnt        <= '0;
            line_cnt       <= '0;
            left_cnt       <= '0;
            pix_cnt        <= '0;
            bit_left       <= '0;
            sh_q           <= '0;
            video_out      <= 1'b0;
            video_stb      <= 1'b0;
            irq_band_begin <= 1'b0;
            irq_page_end   <= 1'b0;
            underrun       <= 1'b0;
        end else begin
            video_stb      <= 1'b0;
            irq_band_begin <= 1'b0;
            irq_page_end   <= 1'b0;
            case (state)
                PV_IDLE: begin
                    if (arm) begin
                        state    <= PV_ARMED;
                        underrun <= 1'b0;
                    end
                end
                PV_ARMED: begin
                    if (fs_rise) begin
                        irq_band_begin <= 1'b1;
                        top_cnt        <= '0;
                        line_cnt       <= '0;
                        state          <= (cfg.top == '0) ? PV_LWAIT : PV_TOP;
                    end
                end
                PV_TOP: begin
                    if (ls_rise) begin
                        top_cnt <= top_cnt + REG_W'(1);
                        if (top_cnt + REG_W'(1) == cfg.top) state <= PV_LWAIT;
                    end
                end
                PV_LWAIT: begin
                    if (ls_rise) begin
                        left_cnt <= '0;
                        pix_cnt  <= '0;
                        bit_left <= '0;
                        state    <= (cfg.left == '0) ? PV_DATA : PV_LEFT;
                    end
                end
                PV_LEFT: begin
                    if (pix_tick) begin
                        left_cnt <= left_cnt + REG_W'(1);
                        if (left_cnt + REG_W'(1) == cfg.left) state <= PV_DATA;
                    end
                end
                PV_DATA: begin
                    if (pix_tick) begin
                        video_stb <= 1'b1;
                        if (bit_left != '0) begin
                            video_out <= sh_q[WORD_W-1];
                            sh_q      <= sh_q << 1;
                            bit_left  <= bit_left - BIT_W'(1);
                        end else if (!empty) begin
                            video_out <= head[WORD_W-1];
                            sh_q      <= head << 1;
                            bit_left  <= BIT_W'(WORD_W - 1);
                        end else begin
                            video_out <= 1'b0;
                            underrun  <= 1'b1;
                        end
                        pix_cnt <= pix_cnt + LINE_PIX_W'(1);
                        if (pix_cnt + LINE_PIX_W'(1) == line_pix) begin
                            line_cnt <= line_cnt + REG_W'(1);
                            if (line_cnt + REG_W'(1) == cfg.lines) begin
                                irq_page_end <= 1'b1;
                                state        <= PV_IDLE;
                            end else begin
                                state <= PV_LWAIT;
                            end
                        end
                    end
                end
                default: state <= PV_IDLE;
            endcase
        end
    end

    // R4
    band_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_band_begin |=> !irq_band_begin);

    // R10
    page_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        irq_page_end |=> (!video_stb && !irq_page_end));

    // R8
    video_tick_align_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(video_out) |-> $past(pix_tick));

    // R11
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (underrun && !fetch_start) |=> underrun);
endmodule

// File: tb/pvid_serializer_tb.sv
module pvid_serializer_tb;
    import pvid_pkg::*;

    localparam int WORD_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic                 cfg_wr = 1'b0;
    logic [REG_IDX_W-1:0] cfg_idx = '0;
    logic [REG_W-1:0]     cfg_wdata = '0;
    logic                 mem_req;
    logic [REG_W-1:0]     mem_addr;
    logic                 mem_ack = 1'b0;
    logic [WORD_W-1:0]    mem_rdata = '0;
    logic                 eng_fsync = 1'b0, eng_lsync = 1'b0, eng_vclk = 1'b0;
    logic                 video_out, video_stb, irq_band_begin, irq_page_end, underrun;

    pvid_serializer u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .eng_fsync(eng_fsync), .eng_lsync(eng_lsync), .eng_vclk(eng_vclk),
        .video_out(video_out), .video_stb(video_stb), .irq_band_begin(irq_band_begin),
        .irq_page_end(irq_page_end), .underrun(underrun)
    );

    int compared = 0, mismatched = 0;
    bit done = 0;
    bit exp_q[$];
    logic [REG_W-1:0] read_log[$];
    bit sb_on = 1;
    int line_stb = 0, first_edge = 0, edge_cnt = 0;
    int band_cnt = 0, page_cnt = 0, reads = 0, mem_lat = 0;

    function automatic logic [15:0] pat(input logic [15:0] a);
        return (a * 16'h9E37) ^ 16'h5A5A;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // memory model
    initial forever begin
        @(negedge clk);
        mem_ack = 1'b0;
        if (mem_req && !rst) begin
            repeat (mem_lat) @(negedge clk);
            mem_rdata = pat(mem_addr);
            read_log.push_back(mem_addr);
            reads++;
            mem_ack = 1'b1;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (irq_band_begin) band_cnt++;
            if (irq_page_end) page_cnt++;
            if (video_stb) begin
                if (line_stb == 0) first_edge = edge_cnt;
                line_stb++;
                if (sb_on) begin
                    if (exp_q.size() == 0) check(0, "R7 unexpected pixel", video_out, 0);
                    else begin
                        bit e;
                        e = exp_q.pop_front();
                        check(video_out == e, "R7 pixel value", video_out, e);
                    end
                end
            end
        end
    end

    task automatic push_page(input int base, input int wpl, input int lines);
        for (int i = 0; i < wpl * lines; i++) begin
            logic [15:0] w;
            w = pat(16'(base + i));
            for (int b = 15; b >= 0; b--) exp_q.push_back(w[b]);
        end
    endtask

    task automatic wr(input int idx, input int val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = REG_IDX_W'(idx); cfg_wdata = REG_W'(val);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load_regs(input int left, input int top, input int wpl, input int lines, input int base);
        wr(0, left); wr(1, top); wr(2, wpl); wr(3, lines); wr(4, base);
    endtask

    task automatic vpulse(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            eng_vclk = 1'b1; edge_cnt++;
            repeat (half) @(negedge clk);
            eng_vclk = 1'b0;
            repeat (half - 1) @(negedge clk);
        end
    endtask

    task automatic line_sync();
        @(negedge clk);
        eng_lsync = 1'b1; edge_cnt = 0; line_stb = 0;
        repeat (4) @(negedge clk);
        eng_lsync = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_sync();
        @(negedge clk);
        eng_fsync = 1'b1;
        repeat (4) @(negedge clk);
        eng_fsync = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic run_line(input int edges, input int half, input int exp_stb,
                            input int exp_first, input string tag);
        line_sync();
        vpulse(edges, half);
        repeat (8) @(negedge clk);
        check(line_stb == exp_stb, {tag, " pixel count"}, line_stb, exp_stb);
        if (exp_stb > 0) check(first_edge == exp_first, {tag, " first pixel clock"}, first_edge, exp_first);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(video_out == 0 && video_stb == 0, "R1 video idle", video_out, 0);
        check(mem_req == 0, "R1 no request", mem_req, 0);
        check(irq_band_begin == 0 && irq_page_end == 0 && underrun == 0, "R1 irq/status low",
              underrun, 0);

        // direct clock page: left 3, top 2, 2 words per line, 3 lines
        push_page(16'h0100, 2, 3);
        load_regs(3, 2, 2, 3, 16'h0100);
        repeat (10) @(negedge clk);
        check(reads == 0, "R2 no arm before control write", reads, 0);
        wr(5, 0);
        repeat (20) @(negedge clk);
        check(reads == 2, "R3 prefetch count", reads, 2);
        check(read_log[0] == 16'h0100, "R3 first prefetch address", read_log[0], 16'h0100);
        check(read_log[1] == 16'h0101, "R3 second prefetch address", read_log[1], 16'h0101);
        check(band_cnt == 0, "R4 no band irq before frame sync", band_cnt, 0);
        frame_sync();
        check(band_cnt == 1, "R4 band irq on frame sync", band_cnt, 1);
        run_line(20, 5, 0, 0, "R5 top margin line 1");
        run_line(20, 5, 0, 0, "R5 top margin line 2");
        for (int l = 0; l < 3; l++) run_line(3 + 32 + 3, 5, 32, 4, "R6 R8 direct data line");
        check(page_cnt == 1, "R10 page end irq", page_cnt, 1);
        check(exp_q.size() == 0, "R7 all pixels sent", exp_q.size(), 0);
        check(reads == 6, "R3 total reads", reads, 6);
        check(underrun == 0, "R11 no underrun", underrun, 0);
        run_line(40, 5, 0, 0, "R10 line after page end");

        // frame sync while idle
        frame_sync();
        check(band_cnt == 1, "R4 frame sync ignored when idle", band_cnt, 1);
        check(reads == 6, "R2 no fetch when idle", reads, 6);

        // recovered clock: left 1, top 0, 1 word per line, 2 lines
        push_page(16'h2000, 1, 2);
        load_regs(1, 0, 1, 2, 16'h2000);
        wr(5, 1);
        repeat (20) @(negedge clk);
        frame_sync();
        check(band_cnt == 2, "R4 band irq recovered page", band_cnt, 2);
        vpulse(3, 3);
        run_line(8 * 18 + 8, 3, 16, 16, "R9 recovered line 1");
        vpulse(5, 3);
        run_line(8 * 18 + 8, 3, 16, 16, "R9 recovered line 2 realigned");
        check(page_cnt == 2, "R10 page end recovered", page_cnt, 2);
        check(exp_q.size() == 0, "R7 recovered pixels sent", exp_q.size(), 0);

        // underrun: slow memory, fast pixels
        sb_on = 0;
        mem_lat = 400;
        load_regs(0, 0, 4, 1, 16'h3000);
        wr(5, 0);
        repeat (900) @(negedge clk);
        frame_sync();
        run_line(64 + 4, 3, 64, 1, "R11 underrun line");
        check(underrun == 1, "R11 underrun set", underrun, 1);
        repeat (2000) @(negedge clk);
        check(underrun == 1, "R11 underrun held", underrun, 1);
        mem_lat = 0;

        // re-arm clears underrun, normal single-word page
        sb_on = 1;
        push_page(16'h4000, 1, 1);
        load_regs(0, 0, 1, 1, 16'h4000);
        wr(5, 0);
        repeat (3) @(negedge clk);
        check(underrun == 0, "R11 underrun cleared on arm", underrun, 0);
        frame_sync();
        run_line(20, 5, 16, 1, "R7 single word line");
        check(page_cnt == 4, "R10 page end count", page_cnt, 4);
        check(exp_q.size() == 0, "R7 single word sent", exp_q.size(), 0);

        finish_run();
    end
endmodule